// File: doc/BRIEF.md
# Byte-Wide Hardware Stack Unit

This block owns the stack pointer of an 8-bit processor and turns stack requests into memory cycles. The stack sits in a fixed 256-byte page at byte address 0x0100 and grows downward. The pointer is a plain byte, so every pointer step wraps inside that page. The block takes four transfer commands: push or pull a byte, and push or pull a 16-bit word. It drives the address, the write data and the write strobe of a byte memory with combinational reads, and it returns the pulled value. A 16-bit push stores its high byte first and its low byte one address below. A 16-bit pull then reads the low byte first. The two pulled bytes are reassembled into the original word.

Two further commands move the pointer to and from the index register. A load sets the pointer from the index input. A copy presents the pointer to the index register with a one-cycle write strobe, together with sign and zero flags for that value. A transfer holds `busy` high for one memory cycle per byte. `done` pulses for one cycle after the last memory cycle. Commands that arrive while `busy` is high are dropped.

Top module: `stack_unit`

## Requirements
- R1: Every stack memory cycle drives `mem_addr` = 0x0100 + an 8-bit pointer value, so the upper address byte is always 0x01.
- R2: After reset `sp_o` is 0xFF, and `busy`, `done`, `mem_we` and `x_we` are all 0.
- R3: Command code 1 (push byte) writes `data_i[7:0]` at 0x0100+SP in one memory cycle, then the pointer becomes SP-1.
- R4: Command code 2 (pull byte) reads address 0x0100+(SP+1) in one memory cycle, with `mem_we` 0. It returns that byte in `pull_o[7:0]` with `pull_o[15:8]` = 0, and the pointer becomes SP+1.
- R5: Command code 3 (push word) writes `data_i[15:8]` at 0x0100+SP in its first cycle. It writes `data_i[7:0]` at 0x0100+(SP-1) in its second cycle. The pointer ends at SP-2.
- R6: Command code 4 (pull word) reads 0x0100+(SP+1) as the low byte and then 0x0100+(SP+2) as the high byte. It returns them in `pull_o`, and the pointer ends at SP+2. A word pushed with code 3 comes back unchanged.
- R7: Pointer arithmetic is modulo 256. A push at pointer 0x00 leaves 0xFF, and a pull at pointer 0xFF reads address 0x0100 and leaves 0x00.
- R8: A command accepted at a clock edge makes `busy` high from that edge for one cycle (byte) or two cycles (word). `done` is high for exactly the one cycle after the last memory cycle, with `busy` low.
- R9: Any command presented while `busy` is high is ignored. The pointer, the memory writes and `pull_o` follow only the command in progress.
- R10: Command code 5 (load) copies `x_i` into the pointer at the accepting edge, with no memory cycle and no `done`.
- R11: Command code 6 (copy) raises `x_we` for one cycle after the accepting edge, with `x_o` = pointer, `flag_n` = bit 7 of the pointer and `flag_z` = 1 only when the pointer is 0. Command code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code, 0 = none |
| data_i | input | 16 | Value to push (byte pushes use bits 7:0) |
| x_i | input | 8 | Index register value for load |
| mem_rdata | input | 8 | Read data of the memory at `mem_addr` |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| pull_o | output | 16 | Pulled value, valid with `done` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sp_o | output | 8 | Current stack pointer |
| x_o | output | 8 | Pointer value for the index register |
| x_we | output | 1 | Index register write strobe |
| flag_n | output | 1 | Sign flag of the copied value |
| flag_z | output | 1 | Zero flag of the copied value |

## Verification
The assertions assume that the memory returns read data in the same cycle as the address. They also assume that the pointer changes only through the block's own commands, with at most one command per cycle on `cmd_i`. The bench models the page as a combinational 256-byte array. It drives each command for a single cycle, away from the clock edge, and waits for `done` before the next transfer, except in the deliberate cases that inject commands during `busy`.

// File: rtl/stack_unit.sv
module stack_unit #(
  parameter int PTR_W = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'h0100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd_i,
  input  logic [2*DATA_W-1:0] data_i,
  input  logic [PTR_W-1:0]    x_i,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic [2*DATA_W-1:0] pull_o,
  output logic                busy,
  output logic                done,
  output logic [PTR_W-1:0]    sp_o,
  output logic [PTR_W-1:0]    x_o,
  output logic                x_we,
  output logic                flag_n,
  output logic                flag_z
);
  localparam int WORD_W = 2 * DATA_W;
  localparam logic [PTR_W-1:0] PTR_RST = '1;
  localparam logic [2:0] C_PUSHB = 3'd1, C_PULLB = 3'd2, C_PUSHW = 3'd3,
                         C_PULLW = 3'd4, C_LOAD = 3'd5, C_COPY = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_ACC1, S_ACC2} st_t;

  st_t               state;
  logic [PTR_W-1:0]  sp;
  logic              is_word, is_pull;
  logic [WORD_W-1:0] hold;
  logic              last;
  logic [PTR_W-1:0]  sp_inc, sp_dec;

  assign sp_inc    = sp + 1'b1;
  assign sp_dec    = sp - 1'b1;
  assign busy      = (state != S_IDLE);
  assign last      = (state == S_ACC2) || (state == S_ACC1 && !is_word);
  assign mem_addr  = PAGE_BASE | ADDR_W'(is_pull ? sp_inc : sp);
  assign mem_we    = busy && !is_pull;
  assign mem_wdata = (state == S_ACC1 && is_word) ? hold[WORD_W-1:DATA_W]
                                                  : hold[DATA_W-1:0];
  assign sp_o      = sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sp      <= PTR_RST;
      is_word <= 1'b0;
      is_pull <= 1'b0;
      hold    <= '0;
      pull_o  <= '0;
      done    <= 1'b0;
      x_we    <= 1'b0;
      x_o     <= '0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
    end else begin
      done <= 1'b0;
      x_we <= 1'b0;
      if (state == S_IDLE) begin
        case (cmd_i)
          C_PUSHB, C_PULLB, C_PUSHW, C_PULLW: begin
            state   <= S_ACC1;
            is_word <= (cmd_i == C_PUSHW) || (cmd_i == C_PULLW);
            is_pull <= (cmd_i == C_PULLB) || (cmd_i == C_PULLW);
            hold    <= data_i;
          end
          C_LOAD: sp <= x_i;
          C_COPY: begin
            x_we   <= 1'b1;
            x_o    <= sp;
            flag_n <= sp[PTR_W-1];
            flag_z <= (sp == '0);
          end
          default: ;
        endcase
      end else begin
        sp <= is_pull ? sp_inc : sp_dec;
        if (is_pull) begin
          if (state == S_ACC1) pull_o <= {{DATA_W{1'b0}}, mem_rdata};
          else                 pull_o[WORD_W-1:DATA_W] <= mem_rdata;
        end
        state <= last ? S_IDLE : S_ACC2;
        done  <= last;
      end
    end
  end

  a_r1_page: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mem_addr[ADDR_W-1:PTR_W] == PAGE_BASE[ADDR_W-1:PTR_W]);
  a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_pull) |=> sp == PTR_W'($past(sp) - 1'b1));
  a_r4_pull_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_pull) |=> sp == PTR_W'($past(sp) + 1'b1));
  a_r4_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy && !is_pull);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r8_word_two: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACC1 && is_word) |=> state == S_ACC2);
  a_r9_hold_op: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(is_pull) && $stable(is_word) && $stable(hold));
  a_r11_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    x_we |=> !x_we);
endmodule

// File: tb/tb_stack_unit.sv
module tb_stack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [15:0] data_i = 16'h0;
  logic [7:0]  x_i = 8'h0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [15:0] pull_o;
  logic        busy, done;
  logic [7:0]  sp_o, x_o;
  logic        x_we, flag_n, flag_z;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] pg  [0:255];
  logic [7:0] mdl [0:255];
  logic [7:0] esp;

  always #10 clk = ~clk;

  stack_unit dut (.*);

  assign mem_rdata = pg[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) pg[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic push_b(input logic [7:0] d);
    @(negedge clk); cmd_i = 3'd1; data_i = {8'hA5, d};
    @(negedge clk); cmd_i = 3'd0;
    chk(busy && mem_we && mem_addr == {8'h01, esp} && mem_wdata == d, "R3/R1 push byte cycle",
        {mem_addr, mem_wdata}, {8'h01, esp, d});
    mdl[esp] = d; esp = esp - 8'd1;
    @(negedge clk);
    chk(done && !busy && sp_o == esp, "R3/R7/R8 push byte end", {done, busy, sp_o}, {2'b10, esp});
  endtask

  task automatic pull_b();
    logic [7:0] a;
    a = esp + 8'd1;
    @(negedge clk); cmd_i = 3'd2;
    @(negedge clk); cmd_i = 3'd0;
    chk(busy && !mem_we && mem_addr == {8'h01, a}, "R4/R1 pull byte cycle", mem_addr, {8'h01, a});
    esp = a;
    @(negedge clk);
    chk(done && !busy && sp_o == esp && pull_o == {8'h00, mdl[a]}, "R4/R7/R8 pull byte end",
        {done, busy, sp_o, pull_o}, {2'b10, esp, 8'h00, mdl[a]});
  endtask

  task automatic push_w(input logic [15:0] w);
    @(negedge clk); cmd_i = 3'd3; data_i = w;
    @(negedge clk); cmd_i = 3'd0;
    chk(busy && mem_we && mem_addr == {8'h01, esp} && mem_wdata == w[15:8], "R5 push word first",
        {mem_addr, mem_wdata}, {8'h01, esp, w[15:8]});
    mdl[esp] = w[15:8]; esp = esp - 8'd1;
    @(negedge clk);
    chk(busy && mem_we && mem_addr == {8'h01, esp} && mem_wdata == w[7:0] && !done, "R5/R8 push word second",
        {mem_addr, mem_wdata}, {8'h01, esp, w[7:0]});
    mdl[esp] = w[7:0]; esp = esp - 8'd1;
    @(negedge clk);
    chk(done && !busy && sp_o == esp, "R5/R8 push word end", {done, busy, sp_o}, {2'b10, esp});
  endtask

  task automatic pull_w();
    logic [7:0] a0, a1;
    a0 = esp + 8'd1; a1 = esp + 8'd2;
    @(negedge clk); cmd_i = 3'd4;
    @(negedge clk); cmd_i = 3'd0;
    chk(busy && !mem_we && mem_addr == {8'h01, a0}, "R6 pull word first", mem_addr, {8'h01, a0});
    @(negedge clk);
    chk(busy && !mem_we && mem_addr == {8'h01, a1} && !done, "R6/R8 pull word second", mem_addr, {8'h01, a1});
    esp = a1;
    @(negedge clk);
    chk(done && !busy && sp_o == esp && pull_o == {mdl[a1], mdl[a0]}, "R6/R7 pull word end",
        {sp_o, pull_o}, {esp, mdl[a1], mdl[a0]});
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); cmd_i = 3'd5; x_i = v;
    @(negedge clk); cmd_i = 3'd0;
    chk(sp_o == v && !busy && !done && !mem_we, "R10 load", {busy, sp_o}, {1'b0, v});
    esp = v;
  endtask

  task automatic copy();
    @(negedge clk); cmd_i = 3'd6;
    @(negedge clk); cmd_i = 3'd0;
    chk(x_we && x_o == esp && flag_n == esp[7] && flag_z == (esp == 8'd0) && !busy, "R11 copy",
        {x_we, x_o, flag_n, flag_z}, {1'b1, esp, esp[7], esp == 8'd0});
    @(negedge clk);
    chk(!x_we, "R11 strobe one cycle", x_we, 1'b0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin pg[i] = 8'h00; mdl[i] = 8'h00; end
    esp = 8'hFF;
    repeat (3) @(negedge clk);
    chk(sp_o == 8'hFF && !busy && !done && !mem_we && !x_we, "R2 reset", {busy, done, sp_o}, {2'b00, 8'hFF});
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_o == 8'hFF && !busy, "R2 after release", sp_o, 8'hFF);

    // R11 idle code 0 does nothing
    repeat (3) @(negedge clk);
    chk(sp_o == 8'hFF && !busy && !done && !x_we, "R11 code 0 idle", sp_o, 8'hFF);

    // R3/R7 byte pushes around the full page and past the wrap
    for (int i = 0; i < 300; i++) push_b(8'(i * 7 + 3));
    for (int i = 0; i < 300; i++) pull_b();

    // R5/R6/R7 word round trip from every start pointer
    for (int p = 0; p < 256; p++) begin
      load(8'(p));
      push_w(16'(p * 16'h0131 + 16'h5A3C));
      pull_w();
    end

    // R10/R11 load and copy over every value
    for (int v = 0; v < 256; v++) begin
      load(8'(v));
      copy();
    end

    // R9 commands during a word push are dropped
    load(8'h40);
    @(negedge clk); cmd_i = 3'd3; data_i = 16'hBEEF;
    @(negedge clk); cmd_i = 3'd2; x_i = 8'h11;
    mdl[8'h40] = 8'hBE;
    @(negedge clk); cmd_i = 3'd5;
    mdl[8'h3F] = 8'hEF;
    @(negedge clk); cmd_i = 3'd0;
    esp = 8'h3E;
    chk(done && sp_o == 8'h3E, "R9 ignored while busy", sp_o, 8'h3E);
    chk(pg[8'h40] == 8'hBE && pg[8'h3F] == 8'hEF, "R9 memory intact", {pg[8'h40], pg[8'h3F]}, 16'hBEEF);
    @(negedge clk);
    chk(!busy && sp_o == 8'h3E, "R9 no late command", {busy, sp_o}, {1'b0, 8'h3E});

    // R9 push during a word pull is dropped
    @(negedge clk); cmd_i = 3'd4;
    @(negedge clk); cmd_i = 3'd1; data_i = 16'h0077;
    @(negedge clk); cmd_i = 3'd0;
    @(negedge clk);
    esp = 8'h40;
    chk(done && sp_o == 8'h40 && pull_o == 16'hBEEF, "R9 pull unaffected", {sp_o, pull_o}, {8'h40, 16'hBEEF});
    chk(pg[8'h3F] == 8'hEF && pg[8'h40] == 8'hBE, "R9 no stray write", {pg[8'h40], pg[8'h3F]}, 16'hBEEF);

    summary();
  end
endmodule